// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Sequencer

This block keeps an asynchronous, multiplexed-address DRAM alive by issuing refresh cycles on its own schedule. A tick-driven interval timer measures the gap between row refreshes. The gap is either the standard 15.6 µs or the extended 125 µs, each given as a tick count parameter. In the spread-out schedule, every expired interval owes one row refresh. In the burst schedule, the block waits one full retention period (ROWS intervals) and then refreshes every row in one back-to-back run.

Before touching the memory pins, the block asks a host arbiter for the bus and waits for a grant. It then drives one of two cycle types. In a row-address refresh, RAS alone pulses low while the block places its own row count on the address pins. In a CAS-first refresh, CAS drops before RAS and the device's internal counter picks the row. The setup, RAS-low and precharge lengths are clock-count parameters. Owed refreshes are counted while the host holds off the grant.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, rasN and casN are 1, addrEn is 0, dramAddr is 0, and refreshReq and refreshBusy are 0.
- R2: The interval timer advances only on cycles with tickEn high. An interval ends after STD_TICKS ticks when extMode is 0, or after EXT_TICKS ticks when extMode is 1.
- R3: With burstMode at 0, each ended interval adds one owed unit, and a unit is one row refresh.
- R4: With burstMode at 1, only every ROWS-th ended interval adds an owed unit. A unit is ROWS refresh cycles run back to back under one grant, with refreshBusy held high throughout.
- R5: Owed units are counted up to MAX_PEND (8). Further units are dropped while the count is full. Each grant serves exactly one unit.
- R6: When the block is idle with a nonzero owed count, refreshReq rises one cycle later. It stays high until the clock edge at which refreshGnt is sampled high, and no DRAM pin moves before that grant.
- R7: In a row-address refresh (cbrMode 0 at the grant), casN stays 1. addrEn is 1 and dramAddr carries the row counter for T_CSR setup cycles with rasN at 1, then for T_RAS cycles with rasN at 0.
- R8: The row counter starts at 0 and advances by one after each row-address refresh, wrapping from ROWS-1 to 0. CAS-first refreshes leave it unchanged. dramAddr is 0 whenever addrEn is 0.
- R9: In a CAS-first refresh (cbrMode 1 at the grant), casN goes low for T_CSR cycles with rasN at 1, then both are low for T_RAS cycles. addrEn stays 0 throughout.
- R10: Every refresh cycle ends with T_RP cycles with rasN and casN both at 1. refreshBusy is high from the cycle after the grant through the last precharge cycle. Outside that window, rasN and casN are 1 and addrEn is 0.
- R11: cbrMode is sampled at the grant, and burstMode decides the unit length at the grant. Changing either during a unit leaves that unit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer tick enable |
| extMode | input | 1 | 1 selects the extended interval |
| burstMode | input | 1 | 1 selects the burst schedule |
| cbrMode | input | 1 | 1 selects CAS-first refresh cycles |
| refreshReq | output | 1 | Bus request to the host arbiter |
| refreshGnt | input | 1 | Bus grant from the host arbiter |
| refreshBusy | output | 1 | Block owns the DRAM pins |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| addrEn | output | 1 | Address pins driven by this block |
| dramAddr | output | ROW_W | Row address for row-address refresh |

## Verification
The assertions check the pin-level rules on every cycle:
- the idle pin state outside a busy window;
- the request holding until its grant and never overlapping busy;
- CAS staying high while the address is driven;
- CAS already low when RAS falls;
- the address holding steady within one refresh;
- RAS never dropping straight after it rises;
- the owed count never exceeding its cap.

Only the bench scenarios can show the quantitative behaviour:
- the interval lengths in both modes;
- the row counter's wrap and its freezing under CAS-first cycles;
- the exact number of rows in a burst;
- the saturation at eight owed units when the grant is withheld;
- mode changes in mid-unit having no effect.

// File: rtl/drfsh_pkg.sv
package drfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_SETUP = 3'd2,
    ST_RAS   = 3'd3,
    ST_PRE   = 3'd4
  } seqState_t;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_RAS   = 2'd1,
    PH_PRE   = 2'd2
  } phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      phaseLoad;
    phaseSel_t phaseSel;
    logic      unitDone;
    logic      rowInc;
    logic      rowsLoad;
    logic      rowsDec;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pendAny;
    logic phaseLast;
    logic rowsLast;
  } dpStatus_t;

endpackage

// File: rtl/drfsh_datapath.sv
module drfsh_datapath
  import drfsh_pkg::*;
#(
  parameter int ROWS      = 4096,
  parameter int STD_TICKS = 1560,
  parameter int EXT_TICKS = 12500,
  parameter int MAX_PEND  = 8,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 4,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              extMode,
  input  logic              burstMode,
  input  seqStrobe_t        strobe,
  output dpStatus_t         status,
  output logic [ROW_W-1:0]  rowAddr,
  output logic [PEND_W-1:0] pendCount
);

  localparam int MAX_TICKS = (EXT_TICKS > STD_TICKS) ? EXT_TICKS : STD_TICKS;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1);
  localparam int MAX_PH0   = (T_CSR > T_RAS) ? T_CSR : T_RAS;
  localparam int MAX_PH    = (MAX_PH0 > T_RP) ? MAX_PH0 : T_RP;
  localparam int PH_W      = $clog2(MAX_PH + 1);
  localparam int RL_W      = ROW_W + 1;

  // interval timer
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] tickLimit;
  logic              intervalEnd;

  assign tickLimit   = extMode ? TICK_W'(EXT_TICKS - 1) : TICK_W'(STD_TICKS - 1);
  assign intervalEnd = tickEn && (tickCnt >= tickLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tickCnt <= '0;
    else if (intervalEnd) tickCnt <= '0;
    else if (tickEn)      tickCnt <= tickCnt + 1'b1;
  end

  // retention-period counter (counts intervals)
  logic [ROW_W-1:0] intervalCnt;
  logic             periodEnd;
  logic             unitAdd;

  assign periodEnd = intervalEnd && (intervalCnt == ROW_W'(ROWS - 1));
  assign unitAdd   = burstMode ? periodEnd : intervalEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          intervalCnt <= '0;
    else if (periodEnd) intervalCnt <= '0;
    else if (intervalEnd) intervalCnt <= intervalCnt + 1'b1;
  end

  // owed-unit counter, saturating
  logic [PEND_W-1:0] pendCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else if (unitAdd && !strobe.unitDone) begin
      if (pendCnt != PEND_W'(MAX_PEND)) pendCnt <= pendCnt + 1'b1;
    end else if (strobe.unitDone && !unitAdd) begin
      pendCnt <= pendCnt - 1'b1;
    end
  end

  // row counter for row-address refresh
  logic [ROW_W-1:0] rowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowCnt <= '0;
    else if (strobe.rowInc) begin
      if (rowCnt == ROW_W'(ROWS - 1)) rowCnt <= '0;
      else                            rowCnt <= rowCnt + 1'b1;
    end
  end

  // phase length counter
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLen;

  always_comb begin
    unique case (strobe.phaseSel)
      PH_SETUP: phaseLen = PH_W'(T_CSR - 1);
      PH_RAS:   phaseLen = PH_W'(T_RAS - 1);
      default:  phaseLen = PH_W'(T_RP - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strobe.phaseLoad) phaseCnt <= phaseLen;
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - 1'b1;
  end

  // rows left in the current unit
  logic [RL_W-1:0] rowsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rowsLeft <= '0;
    else if (strobe.rowsLoad) rowsLeft <= burstMode ? RL_W'(ROWS) : RL_W'(1);
    else if (strobe.rowsDec)  rowsLeft <= rowsLeft - 1'b1;
  end

  assign status.pendAny   = (pendCnt != '0);
  assign status.phaseLast = (phaseCnt == '0);
  assign status.rowsLast  = (rowsLeft == RL_W'(1));
  assign rowAddr          = rowCnt;
  assign pendCount        = pendCnt;

endmodule

// File: rtl/drfsh_ctrl.sv
module drfsh_ctrl
  import drfsh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cbrMode,
  input  logic       refreshGnt,
  input  dpStatus_t  status,
  output seqStrobe_t strobe,
  output logic       refreshReq,
  output logic       refreshBusy,
  output logic       rasN,
  output logic       casN,
  output logic       addrEn
);

  seqState_t state, nextState;
  logic      cbrHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               cbrHeld <= 1'b0;
    else if (state == ST_REQ && refreshGnt)  cbrHeld <= cbrMode;
  end

  always_comb begin
    nextState       = state;
    strobe          = '0;
    strobe.phaseSel = PH_SETUP;
    unique case (state)
      ST_IDLE: begin
        if (status.pendAny) nextState = ST_REQ;
      end
      ST_REQ: begin
        if (refreshGnt) begin
          nextState        = ST_SETUP;
          strobe.phaseLoad = 1'b1;
          strobe.phaseSel  = PH_SETUP;
          strobe.rowsLoad  = 1'b1;
        end
      end
      ST_SETUP: begin
        if (status.phaseLast) begin
          nextState        = ST_RAS;
          strobe.phaseLoad = 1'b1;
          strobe.phaseSel  = PH_RAS;
        end
      end
      ST_RAS: begin
        if (status.phaseLast) begin
          nextState        = ST_PRE;
          strobe.phaseLoad = 1'b1;
          strobe.phaseSel  = PH_PRE;
          strobe.rowInc    = !cbrHeld;
        end
      end
      ST_PRE: begin
        if (status.phaseLast) begin
          if (status.rowsLast) begin
            nextState       = ST_IDLE;
            strobe.unitDone = 1'b1;
          end else begin
            nextState        = ST_SETUP;
            strobe.phaseLoad = 1'b1;
            strobe.phaseSel  = PH_SETUP;
            strobe.rowsDec   = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  logic strobePhase;
  assign strobePhase = (state == ST_SETUP) || (state == ST_RAS);

  assign refreshReq  = (state == ST_REQ);
  assign refreshBusy = strobePhase || (state == ST_PRE);
  assign rasN        = (state != ST_RAS);
  assign casN        = !(strobePhase && cbrHeld);
  assign addrEn      = strobePhase && !cbrHeld;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import drfsh_pkg::*;
#(
  parameter int ROWS      = 4096,
  parameter int STD_TICKS = 1560,
  parameter int EXT_TICKS = 12500,
  parameter int MAX_PEND  = 8,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 4,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             extMode,
  input  logic             burstMode,
  input  logic             cbrMode,
  output logic             refreshReq,
  input  logic             refreshGnt,
  output logic             refreshBusy,
  output logic             rasN,
  output logic             casN,
  output logic             addrEn,
  output logic [ROW_W-1:0] dramAddr
);

  seqStrobe_t        strobe;
  dpStatus_t         status;
  logic [ROW_W-1:0]  rowAddr;
  logic [PEND_W-1:0] pendCount;

  drfsh_datapath #(
    .ROWS(ROWS), .STD_TICKS(STD_TICKS), .EXT_TICKS(EXT_TICKS),
    .MAX_PEND(MAX_PEND), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extMode(extMode),
    .burstMode(burstMode), .strobe(strobe), .status(status),
    .rowAddr(rowAddr), .pendCount(pendCount)
  );

  drfsh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cbrMode(cbrMode), .refreshGnt(refreshGnt),
    .status(status), .strobe(strobe), .refreshReq(refreshReq),
    .refreshBusy(refreshBusy), .rasN(rasN), .casN(casN), .addrEn(addrEn)
  );

  assign dramAddr = addrEn ? rowAddr : '0;

endmodule

// File: rtl/drfsh_checker.sv
module drfsh_checker #(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = 4,
  parameter int ADDR_W   = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              refreshReq,
  input logic              refreshGnt,
  input logic              refreshBusy,
  input logic              rasN,
  input logic              casN,
  input logic              addrEn,
  input logic [ADDR_W-1:0] dramAddr,
  input logic [PEND_W-1:0] pendCount
);

  assert_idle_pins_R10: assert property (@(posedge clk) disable iff (!rstN)
    !refreshBusy |-> (rasN && casN && !addrEn));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (refreshReq && !refreshGnt) |=> refreshReq);

  assert_req_not_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |-> !refreshBusy);

  assert_cas_high_rasonly_R7: assert property (@(posedge clk) disable iff (!rstN)
    addrEn |-> casN);

  assert_cas_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casN) |-> !$past(casN));

  assert_addr_steady_R8: assert property (@(posedge clk) disable iff (!rstN)
    (addrEn && $past(addrEn)) |-> $stable(dramAddr));

  assert_precharge_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |=> rasN);

  assert_pend_cap_R5: assert property (@(posedge clk) disable iff (!rstN)
    pendCount <= PEND_W'(MAX_PEND));

endmodule

bind dram_refresh_sched drfsh_checker #(
  .MAX_PEND(MAX_PEND), .PEND_W(PEND_W), .ADDR_W(ROW_W)
) u_chk (
  .clk(clk), .rstN(rstN), .refreshReq(refreshReq), .refreshGnt(refreshGnt),
  .refreshBusy(refreshBusy), .rasN(rasN), .casN(casN), .addrEn(addrEn),
  .dramAddr(dramAddr), .pendCount(pendCount)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;

  localparam int ROWS_T = 8;
  localparam int STD_T  = 10;
  localparam int EXT_T  = 23;
  localparam int PEND_T = 8;
  localparam int CSR_T  = 2;
  localparam int RAS_T  = 3;
  localparam int RP_T   = 2;
  localparam int AW     = $clog2(ROWS_T);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, extMode = 1'b0, burstMode = 1'b0, cbrMode = 1'b0;
  logic refreshGnt = 1'b0;
  logic refreshReq, refreshBusy, rasN, casN, addrEn;
  logic [AW-1:0] dramAddr;

  always #2 clk = ~clk;

  dram_refresh_sched #(
    .ROWS(ROWS_T), .STD_TICKS(STD_T), .EXT_TICKS(EXT_T), .MAX_PEND(PEND_T),
    .T_CSR(CSR_T), .T_RAS(RAS_T), .T_RP(RP_T)
  ) u_dram_refresh_sched (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extMode(extMode),
    .burstMode(burstMode), .cbrMode(cbrMode), .refreshReq(refreshReq),
    .refreshGnt(refreshGnt), .refreshBusy(refreshBusy), .rasN(rasN),
    .casN(casN), .addrEn(addrEn), .dramAddr(dramAddr)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct { bit ras; bit cas; bit ae; int addr; } pinWord_t;
  pinWord_t q[$];
  pinWord_t cur;
  int mTick, mIntv, mPend, mRow, mSt;

  function automatic pinWord_t idleWord();
    pinWord_t w; w.ras = 1; w.cas = 1; w.ae = 0; w.addr = 0; return w;
  endfunction

  task automatic buildUnit();
    int n = burstMode ? ROWS_T : 1;
    bit cbr = cbrMode;
    for (int i = 0; i < n; i++) begin
      pinWord_t w;
      w.cas = !cbr; w.ae = !cbr; w.addr = cbr ? 0 : mRow;
      w.ras = 1;
      for (int k = 0; k < CSR_T; k++) q.push_back(w);
      w.ras = 0;
      for (int k = 0; k < RAS_T; k++) q.push_back(w);
      for (int k = 0; k < RP_T; k++) q.push_back(idleWord());
      if (!cbr) mRow = (mRow + 1) % ROWS_T;
    end
  endtask

  task automatic modelStep();
    bit expd, add, done;
    int lim;
    if (!rstN) begin
      mTick = 0; mIntv = 0; mPend = 0; mRow = 0; mSt = 0;
      q.delete(); cur = idleWord();
      return;
    end
    expd = 0; add = 0; done = 0;
    if (tickEn) begin
      lim = extMode ? EXT_T : STD_T;
      if (mTick >= lim - 1) begin mTick = 0; expd = 1; end
      else mTick++;
    end
    if (expd) begin
      add = burstMode ? (mIntv == ROWS_T - 1) : 1'b1;
      mIntv = (mIntv == ROWS_T - 1) ? 0 : mIntv + 1;
    end
    case (mSt)
      0: if (mPend > 0) mSt = 1;
      1: if (refreshGnt) begin buildUnit(); cur = q.pop_front(); mSt = 2; end
      default: begin
        if (q.size() == 0) begin mSt = 0; done = 1; cur = idleWord(); end
        else cur = q.pop_front();
      end
    endcase
    mPend = mPend + int'(add) - int'(done);
    if (mPend > PEND_T) mPend = PEND_T;
  endtask

  // monitor counters
  int rasFalls = 0, windowFalls = 0, lastWindow = 0, aeHigh = 0, maxWindow = 0;
  logic prevRas = 1'b1, prevBusy = 1'b0;

  always @(posedge clk) begin
    modelStep();
    #1;
    check(refreshReq == (mSt == 1), "R6", "refreshReq", refreshReq, mSt == 1);
    check(refreshBusy == (mSt == 2), "R10", "refreshBusy", refreshBusy, mSt == 2);
    check(rasN == cur.ras, "R10", "rasN", rasN, cur.ras);
    check(casN == cur.cas, "R9", "casN", casN, cur.cas);
    check(addrEn == cur.ae, "R7", "addrEn", addrEn, cur.ae);
    check(int'(dramAddr) == cur.addr, "R8", "dramAddr", dramAddr, cur.addr);
    if (prevRas && !rasN) begin rasFalls++; windowFalls++; end
    if (addrEn) aeHigh++;
    if (prevBusy && !refreshBusy) begin
      lastWindow = windowFalls;
      if (windowFalls > maxWindow) maxWindow = windowFalls;
      windowFalls = 0;
    end
    prevRas = rasN; prevBusy = refreshBusy;
  end

  // ---------------- grant responder ----------------
  bit gntEnable = 1;
  int gntDelay = 1;

  task automatic grantResponder();
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (gntEnable && refreshReq) begin
        if (waitCnt >= gntDelay) begin refreshGnt = 1; waitCnt = 0; end
        else begin refreshGnt = 0; waitCnt++; end
      end else begin
        refreshGnt = 0; waitCnt = 0;
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; tickEn = 0;
    repeat (3) @(negedge clk);
    rasFalls = 0; windowFalls = 0; lastWindow = 0; aeHigh = 0; maxWindow = 0;
    rstN = 1;
  endtask

  task automatic runTicks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tickEn = 1;
      @(negedge clk);
      tickEn = 0;
      for (int g = 1; g < gap; g++) @(negedge clk);
    end
    tickEn = 0;
  endtask

  task automatic idleWait(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    fork grantResponder(); join_none
    doReset();
    @(negedge clk);
    check(rasN && casN, "R1", "strobes after reset", {rasN, casN}, 3);
    check(!addrEn && dramAddr == 0, "R1", "address after reset", dramAddr, 0);
    check(!refreshReq && !refreshBusy, "R1", "req/busy after reset", {refreshReq, refreshBusy}, 0);

    // R3 / R8: spread-out schedule, row-address refresh, row wraps twice
    extMode = 0; burstMode = 0; cbrMode = 0;
    runTicks(200, 1);
    idleWait(40);
    check(rasFalls == 20, "R3", "one refresh per interval", rasFalls, 20);
    check(maxWindow == 1, "R3", "rows per grant", maxWindow, 1);

    // R2: extended interval, ticks every third cycle
    doReset();
    extMode = 1;
    runTicks(5 * EXT_T, 3);
    idleWait(40);
    check(rasFalls == 5, "R2", "extended interval count", rasFalls, 5);

    // R9: CAS-first cycles never drive the address
    doReset();
    extMode = 0; cbrMode = 1;
    runTicks(100, 1);
    idleWait(40);
    check(rasFalls == 10, "R9", "CAS-first refresh count", rasFalls, 10);
    check(aeHigh == 0, "R9", "address enable cycles", aeHigh, 0);
    // R8: counter unchanged by CAS-first cycles; next row-address refresh uses row 0
    cbrMode = 0;
    runTicks(STD_T, 1);
    idleWait(30);
    check(aeHigh == CSR_T + RAS_T, "R8", "address enable cycles after switch", aeHigh, CSR_T + RAS_T);

    // R4: burst schedule
    doReset();
    burstMode = 1;
    runTicks(2 * ROWS_T * STD_T, 1);
    idleWait(100);
    check(rasFalls == 2 * ROWS_T, "R4", "burst refresh count", rasFalls, 2 * ROWS_T);
    check(lastWindow == ROWS_T, "R4", "rows in one burst", lastWindow, ROWS_T);

    // R5 / R6: grant withheld, owed count saturates
    doReset();
    burstMode = 0; gntEnable = 0;
    runTicks(15 * STD_T, 1);
    idleWait(5);
    check(refreshReq == 1, "R6", "request held without grant", refreshReq, 1);
    check(rasFalls == 0, "R6", "no strobe before grant", rasFalls, 0);
    gntEnable = 1; gntDelay = 3;
    idleWait(200);
    check(rasFalls == PEND_T, "R5", "refreshes after saturation", rasFalls, PEND_T);
    check(maxWindow == 1, "R5", "one unit per grant", maxWindow, 1);

    // R11: mode inputs toggled during units
    doReset();
    burstMode = 1; gntDelay = 0;
    fork
      runTicks(2 * ROWS_T * STD_T, 1);
      begin
        for (int i = 0; i < 40; i++) begin
          idleWait(5);
          cbrMode = ~cbrMode;
        end
        burstMode = 1;
      end
    join
    idleWait(100);
    check(rasFalls == 2 * ROWS_T, "R11", "burst length with toggling method", rasFalls, 2 * ROWS_T);

    // R11: burst input dropped mid-burst keeps the full burst
    doReset();
    burstMode = 1; cbrMode = 0;
    runTicks(ROWS_T * STD_T, 1);
    idleWait(4);
    burstMode = 0;
    idleWait(80);
    check(lastWindow == ROWS_T, "R11", "burst unaffected by mode change", lastWindow, ROWS_T);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule